// File: doc/BRIEF.md
# UART Interrupt Controller

This block drives the single active-high interrupt request of a 16550-class serial port. It holds an 8-bit enable register and takes event inputs from the rest of the UART. Level-type conditions come in as they are: receive data available and a pending modem-status change. Edge- and strobe-type conditions are latched internally: line-status errors, the transmit holding register becoming empty, a received flow-control stop character, and rising transitions on the clear-to-send and request-to-send lines.

The host reads a 4-bit identification code that names the most urgent pending source that is enabled. Each latched source is cleared by its own host action. Bit 4 of the enable register does not gate any source; it is exported as a sleep enable for the power logic.

The CTS and RTS lines may be asynchronous. They pass through a synchroniser whose depth is set by a parameter before their rising edges are detected.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, `irq_o` is low and `iir_o` is 4'b0001.
- R2: A write strobe loads `ier_wdata_i` into the enable register, and `ier_o` shows the new value after the next clock edge. `sleep_en_o` follows enable bit 4, and that bit gates no interrupt source.
- R3: The codes, from highest priority to lowest, are: line status 4'b0110, receive ready 4'b0100, transmit empty 4'b0010, modem status 4'b0000, stop character 4'b1000, CTS/RTS edge 4'b1100. When nothing enabled is pending the code is 4'b0001. `iir_o` shows the highest pending enabled source.
- R4: A `line_err_i` strobe latches a line-status event. The event stays pending until `lsr_rd_i` and is reported only when enable bit 2 is set.
- R5: Receive-ready follows the `rx_ready_i` level and is gated by enable bit 0.
- R6: Transmit-empty is latched in two cases: on a rising edge of `thr_empty_i`, and on an enable write that sets bit 1 from 0 while `thr_empty_i` is high. It is gated by bit 1. It clears on `thr_wr_i`, or on `iir_rd_i` while it is the reported source. A new set in the same cycle as a clear wins.
- R7: Modem status follows the `modem_chg_i` level and is gated by enable bit 3.
- R8: An `xoff_rx_i` strobe latches a stop-character event. It is gated by bit 5 and clears on `iir_rd_i` while it is the reported source.
- R9: A rising edge of `cts_i` or `rts_i` is latched after a synchroniser of SYNC_STAGES flops. The code appears SYNC_STAGES+1 clock edges after the first edge that samples the line high. Bit 7 gates CTS and bit 6 gates RTS. An `iir_rd_i` while the edge code is reported clears both latches.
- R10: Latched events are captured whether or not they are enabled. Setting the enable bit later reports them.
- R11: `irq_o` is high exactly when `iir_o[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register contents |
| sleep_en_o | output | 1 | Sleep enable (enable bit 4) |
| iir_rd_i | input | 1 | Host read of the identification code |
| iir_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |
| rx_ready_i | input | 1 | Receive data available (level) |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| thr_wr_i | input | 1 | Host write of the transmit holding register |
| line_err_i | input | 1 | Line-status error strobe |
| lsr_rd_i | input | 1 | Host read of line status |
| modem_chg_i | input | 1 | Modem status change pending (level) |
| xoff_rx_i | input | 1 | Stop character received strobe |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| rts_i | input | 1 | Request-to-send line, asynchronous |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This makes the edge latency at the code output four clock edges, so an off-by-one in the synchroniser depth shows up as a code appearing one cycle early or late. A long random phase also overlaps sets and clears in the same cycle and mixes enable writes with pending events. This reaches the set-wins case and the priority masking between every pair of sources.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 8;
  localparam int IID_W = 4;
  localparam int NSRC  = 6;

  // enable bit positions
  localparam int IE_RX    = 0;
  localparam int IE_THR   = 1;
  localparam int IE_LINE  = 2;
  localparam int IE_MODEM = 3;
  localparam int IE_SLEEP = 4;
  localparam int IE_XOFF  = 5;
  localparam int IE_RTS   = 6;
  localparam int IE_CTS   = 7;

  // source index == priority rank (0 highest)
  localparam int SRC_LINE  = 0;
  localparam int SRC_RX    = 1;
  localparam int SRC_THR   = 2;
  localparam int SRC_MODEM = 3;
  localparam int SRC_XOFF  = 4;
  localparam int SRC_FLOW  = 5;

  localparam logic [IID_W-1:0] IID_NONE  = 4'b0001;
  localparam logic [IID_W-1:0] IID_LINE  = 4'b0110;
  localparam logic [IID_W-1:0] IID_RX    = 4'b0100;
  localparam logic [IID_W-1:0] IID_THR   = 4'b0010;
  localparam logic [IID_W-1:0] IID_MODEM = 4'b0000;
  localparam logic [IID_W-1:0] IID_XOFF  = 4'b1000;
  localparam logic [IID_W-1:0] IID_FLOW  = 4'b1100;

  function automatic logic [IID_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LINE:  return IID_LINE;
      SRC_RX:    return IID_RX;
      SRC_THR:   return IID_THR;
      SRC_MODEM: return IID_MODEM;
      SRC_XOFF:  return IID_XOFF;
      SRC_FLOW:  return IID_FLOW;
      default:   return IID_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_sync_edge.sv
module uart_irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];

  assign rise_o = sr_q[STAGES-1] & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;

  AST_SET_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o); // R6
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_gnt
      if (g == 0) begin : g_top
        assign grant_o[g] = req_i[g];
      end else begin : g_rest
        assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
      end
    end
  endgenerate

  assign any_o = |req_i;

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant_o)); // R3
    AST_GRANT_IFF_REQ: assert ((grant_o != '0) == (req_i != '0)); // R3
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [IER_W-1:0] ier_wdata_i,
  output logic [IER_W-1:0] ier_o,
  output logic             sleep_en_o,
  input  logic             iir_rd_i,
  output logic [IID_W-1:0] iir_o,
  output logic             irq_o,
  input  logic             rx_ready_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             line_err_i,
  input  logic             lsr_rd_i,
  input  logic             modem_chg_i,
  input  logic             xoff_rx_i,
  input  logic             cts_i,
  input  logic             rts_i
);
  logic [IER_W-1:0] ier_q;
  logic             thr_empty_q;
  logic             cts_rise, rts_rise;
  logic             line_p, thr_p, xoff_p, cts_p, rts_p;
  logic             thr_set, rd_thr, rd_xoff, rd_flow;
  logic [NSRC-1:0]  req, grant;
  logic             any;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       ier_q <= '0;
    else if (ier_wr_i) ier_q <= ier_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) thr_empty_q <= 1'b0;
    else         thr_empty_q <= thr_empty_i;

  uart_irq_sync_edge #(.STAGES(SYNC_STAGES)) u_cts (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_i), .rise_o(cts_rise));
  uart_irq_sync_edge #(.STAGES(SYNC_STAGES)) u_rts (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rts_i), .rise_o(rts_rise));

  // enabling the source while already empty re-arms it
  assign thr_set = (thr_empty_i & ~thr_empty_q)
                 | (ier_wr_i & ier_wdata_i[IE_THR] & ~ier_q[IE_THR] & thr_empty_i);
  assign rd_thr  = iir_rd_i & grant[SRC_THR];
  assign rd_xoff = iir_rd_i & grant[SRC_XOFF];
  assign rd_flow = iir_rd_i & grant[SRC_FLOW];

  uart_irq_latch u_line (.clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(line_err_i), .clr_i(lsr_rd_i), .pend_o(line_p));
  uart_irq_latch u_thr (.clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(thr_set), .clr_i(thr_wr_i | rd_thr), .pend_o(thr_p));
  uart_irq_latch u_xoff (.clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(xoff_rx_i), .clr_i(rd_xoff), .pend_o(xoff_p));
  uart_irq_latch u_ctsl (.clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(cts_rise), .clr_i(rd_flow), .pend_o(cts_p));
  uart_irq_latch u_rtsl (.clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(rts_rise), .clr_i(rd_flow), .pend_o(rts_p));

  assign req[SRC_LINE]  = line_p      & ier_q[IE_LINE];
  assign req[SRC_RX]    = rx_ready_i  & ier_q[IE_RX];
  assign req[SRC_THR]   = thr_p       & ier_q[IE_THR];
  assign req[SRC_MODEM] = modem_chg_i & ier_q[IE_MODEM];
  assign req[SRC_XOFF]  = xoff_p      & ier_q[IE_XOFF];
  assign req[SRC_FLOW]  = (cts_p & ier_q[IE_CTS]) | (rts_p & ier_q[IE_RTS]);

  uart_irq_prio #(.N(NSRC)) u_prio (.req_i(req), .grant_o(grant), .any_o(any));

  always_comb begin
    iir_o = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--)
      if (grant[i]) iir_o = src_code(i);
  end

  assign irq_o      = any;
  assign ier_o      = ier_q;
  assign sleep_en_o = ier_q[IE_SLEEP];

  AST_IER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr_i |=> ier_o == $past(ier_wdata_i)); // R2
  AST_IRQ_VS_IID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]); // R11
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_p && !lsr_rd_i) |=> line_p); // R4
  AST_THR_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !thr_set) |=> !thr_p); // R6
  AST_XOFF_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_xoff && !xoff_rx_i) |=> !xoff_p); // R8
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ier_wr = 0; logic [7:0] ier_wdata = 0;
  logic [7:0] ier_o; logic sleep_en_o;
  logic iir_rd = 0; logic [3:0] iir_o; logic irq_o;
  logic rx_ready = 0, thr_empty = 0, thr_wr = 0, line_err = 0, lsr_rd = 0;
  logic modem_chg = 0, xoff_rx = 0, cts = 0, rts = 0;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wdata),
    .ier_o(ier_o), .sleep_en_o(sleep_en_o), .iir_rd_i(iir_rd), .iir_o(iir_o),
    .irq_o(irq_o), .rx_ready_i(rx_ready), .thr_empty_i(thr_empty),
    .thr_wr_i(thr_wr), .line_err_i(line_err), .lsr_rd_i(lsr_rd),
    .modem_chg_i(modem_chg), .xoff_rx_i(xoff_rx), .cts_i(cts), .rts_i(rts));

  // ---------------- reference model ----------------
  logic [7:0] m_ier;
  bit m_line, m_tx, m_xoff, m_cts, m_rts, m_thr_prev;
  bit cq[0:SYNC];
  bit rq[0:SYNC];

  function automatic logic [3:0] m_code();
    if (m_line && m_ier[2])                              return 4'b0110;
    if (rx_ready && m_ier[0])                            return 4'b0100;
    if (m_tx && m_ier[1])                                return 4'b0010;
    if (modem_chg && m_ier[3])                           return 4'b0000;
    if (m_xoff && m_ier[5])                              return 4'b1000;
    if ((m_cts && m_ier[7]) || (m_rts && m_ier[6]))      return 4'b1100;
    return 4'b0001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = 0; m_line = 0; m_tx = 0; m_xoff = 0; m_cts = 0; m_rts = 0;
      m_thr_prev = 0;
      for (int j = 0; j <= SYNC; j++) begin cq[j] = 0; rq[j] = 0; end
    end else begin
      logic [3:0] c;
      bit tx_set, ce, re;
      c = m_code();
      tx_set = (thr_empty && !m_thr_prev) ||
               (ier_wr && ier_wdata[1] && !m_ier[1] && thr_empty);
      ce = cq[SYNC-1] && !cq[SYNC];
      re = rq[SYNC-1] && !rq[SYNC];
      if (tx_set) m_tx = 1; else if (thr_wr || (iir_rd && c == 4'b0010)) m_tx = 0;
      if (line_err) m_line = 1; else if (lsr_rd) m_line = 0;
      if (xoff_rx) m_xoff = 1; else if (iir_rd && c == 4'b1000) m_xoff = 0;
      if (ce) m_cts = 1; else if (iir_rd && c == 4'b1100) m_cts = 0;
      if (re) m_rts = 1; else if (iir_rd && c == 4'b1100) m_rts = 0;
      m_thr_prev = thr_empty;
      if (ier_wr) m_ier = ier_wdata;
      for (int j = SYNC; j > 0; j--) begin cq[j] = cq[j-1]; rq[j] = rq[j-1]; end
      cq[0] = cts; rq[0] = rts;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 4;
      if (ier_o !== m_ier) begin errors++;
        $display("FAIL R2 model ier_o act %h exp %h", ier_o, m_ier); end
      if (sleep_en_o !== m_ier[4]) begin errors++;
        $display("FAIL R2 model sleep act %b exp %b", sleep_en_o, m_ier[4]); end
      if (iir_o !== m_code()) begin errors++;
        $display("FAIL R3 model iir act %b exp %b", iir_o, m_code()); end
      if (irq_o !== (m_code() != 4'b0001)) begin errors++;
        $display("FAIL R11 model irq act %b exp %b", irq_o, m_code() != 4'b0001); end
    end
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic iw(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; step(); ier_wr = 0;
  endtask

  task automatic rd();
    iir_rd = 1; step(); iir_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog act %0d exp <150000", cycles);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    #(CLK_PERIOD*2 + 1);
    rst_n = 1;
    step();
    chk("R1 ier", ier_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    chk("R1 iir", {4'b0, iir_o}, 8'h01);

    // R2 sleep bit gates nothing
    rx_ready = 1; iw(8'h10);
    chk("R2 ier", ier_o, 8'h10);
    chk("R2 sleep", {7'b0, sleep_en_o}, 8'h01);
    chk("R2 no irq", {7'b0, irq_o}, 8'h00);

    // R5
    iw(8'h01);
    chk("R5 rx", {4'b0, iir_o}, 8'h04);
    rx_ready = 0; step();
    chk("R5 rx low", {4'b0, iir_o}, 8'h01);

    // R10 / R4 / R3
    line_err = 1; step(); line_err = 0;
    chk("R10 masked line", {7'b0, irq_o}, 8'h00);
    iw(8'h05);
    chk("R10 line reported", {4'b0, iir_o}, 8'h06);
    rx_ready = 1; step();
    chk("R3 line over rx", {4'b0, iir_o}, 8'h06);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R4 lsr clears", {4'b0, iir_o}, 8'h04);
    rx_ready = 0; step();

    // R6
    iw(8'h02);
    thr_empty = 1; step();
    chk("R6 empty rise", {4'b0, iir_o}, 8'h02);
    rd();
    chk("R6 read clears", {4'b0, iir_o}, 8'h01);
    thr_empty = 0; step(); thr_empty = 1; step();
    chk("R6 second rise", {4'b0, iir_o}, 8'h02);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R6 write clears", {4'b0, iir_o}, 8'h01);
    iw(8'h00); iw(8'h02);
    chk("R6 rearm on enable", {4'b0, iir_o}, 8'h02);
    thr_wr = 1; step(); thr_wr = 0; thr_empty = 0; step();

    // R7 / R3
    iw(8'h0A); modem_chg = 1; step();
    chk("R7 modem", {4'b0, iir_o}, 8'h00);
    chk("R11 irq with code 0", {7'b0, irq_o}, 8'h01);
    thr_empty = 1; step();
    chk("R3 thr over modem", {4'b0, iir_o}, 8'h02);
    thr_wr = 1; step(); thr_wr = 0;
    chk("R7 modem again", {4'b0, iir_o}, 8'h00);
    modem_chg = 0; thr_empty = 0; step();
    chk("R7 modem low", {4'b0, iir_o}, 8'h01);

    // R8
    iw(8'h20); xoff_rx = 1; step(); xoff_rx = 0;
    chk("R8 xoff", {4'b0, iir_o}, 8'h08);
    rd();
    chk("R8 read clears", {4'b0, iir_o}, 8'h01);

    // R9 latency
    iw(8'h80); cts = 1;
    for (int i = 0; i < SYNC; i++) step();
    chk("R9 not yet", {4'b0, iir_o}, 8'h01);
    step();
    chk("R9 cts edge", {4'b0, iir_o}, 8'h0C);
    rd();
    chk("R9 read clears", {4'b0, iir_o}, 8'h01);
    cts = 0; rts = 1;
    for (int i = 0; i < SYNC + 3; i++) step();
    chk("R9 rts masked", {7'b0, irq_o}, 8'h00);
    iw(8'hC0);
    chk("R10 rts reported", {4'b0, iir_o}, 8'h0C);
    rd();
    chk("R9 rts cleared", {4'b0, iir_o}, 8'h01);
    rts = 0; step();

    // random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      ier_wr    = ($urandom % 16) == 0;
      ier_wdata = 8'($urandom);
      iir_rd    = ($urandom % 6) == 0;
      line_err  = ($urandom % 12) == 0;
      lsr_rd    = ($urandom % 10) == 0;
      xoff_rx   = ($urandom % 12) == 0;
      thr_wr    = ($urandom % 10) == 0;
      if (($urandom % 5) == 0) rx_ready  = ~rx_ready;
      if (($urandom % 6) == 0) thr_empty = ~thr_empty;
      if (($urandom % 8) == 0) modem_chg = ~modem_chg;
      if (($urandom % 7) == 0) cts       = ~cts;
      if (($urandom % 7) == 0) rts       = ~rts;
      step();
    end
    ier_wr = 0; iir_rd = 0; line_err = 0; lsr_rd = 0; xoff_rx = 0; thr_wr = 0;
    step(); step();
    finish_run();
  end
endmodule